// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Phase Controller

This block closes the digital half of a first-order bang-bang clock-recovery loop. It gets a receiver that samples twice per symbol, once mid-symbol for data and once at the boundary. Each qualified symbol it takes the current data decision, the previous data decision and the boundary sample between them, and judges whether the sampling clock sits ahead of or behind the data crossing. Symbols without a data crossing carry no timing information and are discarded.

The per-symbol judgements are summed over a fixed window of qualified symbols. When a window closes, the sign of the sum becomes at most one step command, and the accumulator starts again from zero. The step moves an 8-bit position code that selects a phase-interpolator setting. The code saturates at both ends of its range instead of wrapping. A synchronous load places the position at a programmed value and restarts the window.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: When the two data decisions differ, a boundary sample equal to the current decision counts as an ahead vote (value -1, requests a downward step), and a boundary sample equal to the previous decision counts as a behind vote (value +1, requests an upward step).
- R2: When the two data decisions are equal, the symbol adds nothing to the sum but still counts toward the window length.
- R3: A window is 4 qualified symbols (`smp_valid` high, `init_load` low). The decision is taken on the fourth symbol, including that symbol's vote, and the sum and symbol count then restart at zero.
- R4: A window sum above zero gives a one-cycle `step_up` pulse, a sum below zero gives a one-cycle `step_dn` pulse, and a zero sum gives neither. The two are never high together and are low in every cycle that does not follow a window close.
- R5: `phase_code` rises by one on the same clock edge that raises `step_up`, falls by one on the edge that raises `step_dn`, and otherwise keeps its value, except when a load occurs.
- R6: `phase_code` saturates. An upward step at 255 leaves it at 255 and a downward step at 0 leaves it at 0, while the step pulse itself is still issued.
- R7: `init_load` high at a clock edge sets `phase_code` to `init_phase`, clears the sum and symbol count, and gives no step on that edge. It takes priority over `smp_valid`.
- R8: While `rst_n` is low, `phase_code` is 128 and both step outputs are low.
- R9: A cycle with `smp_valid` low changes nothing: no vote, no window progress, no step and no phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_load | input | 1 | Synchronous load of the phase position and restart of the window |
| init_phase | input | 8 | Position written by `init_load` |
| smp_valid | input | 1 | Qualifies the three samples in this cycle |
| d_cur | input | 1 | Current mid-symbol data decision |
| d_prev | input | 1 | Previous mid-symbol data decision |
| e_smp | input | 1 | Boundary sample taken between the two data decisions |
| step_up | output | 1 | One-cycle pulse: the window asked for a later phase |
| step_dn | output | 1 | One-cycle pulse: the window asked for an earlier phase |
| phase_code | output | 8 | Phase-interpolator select position |

## Verification
A window close can fall in the same cycle as a saturation limit, and a window close can fall in the same cycle as a load. The bench loads positions 254 and 1 and then drives windows made only of behind votes or only of ahead votes. At the limit it expects the step pulse to be present while the code stays put. A long pseudo-random sequence drops loads at arbitrary points in a window. A cycle-accurate model in the bench, built from the requirements, judges every cycle, and loads always win over the window decision.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic [1:0] {
    VOTE_NONE  = 2'b00,
    VOTE_LATE  = 2'b01,
    VOTE_EARLY = 2'b10
  } vote_t;

  localparam int unsigned RESET_PHASE_DEF = 128;

endpackage

// File: rtl/cdr_edge_classifier.sv
module cdr_edge_classifier
  import cdr_pkg::*;
(
  input  logic  d_cur,
  input  logic  d_prev,
  input  logic  e_smp,
  output vote_t vote
);

  logic crossing;
  logic edge_matches_new;

  always_comb begin
    crossing         = d_cur ^ d_prev;
    edge_matches_new = ~(e_smp ^ d_cur);
    if (!crossing) begin
      vote = VOTE_NONE;
    end else if (edge_matches_new) begin
      vote = VOTE_EARLY;
    end else begin
      vote = VOTE_LATE;
    end
  end

endmodule

// File: rtl/cdr_vote_filter.sv
module cdr_vote_filter
  import cdr_pkg::*;
#(
  parameter int unsigned WIN_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  vote_t vote,
  output logic  dec_up,
  output logic  dec_dn,
  output logic  step_up,
  output logic  step_dn
);

  localparam int unsigned CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned ACC_W = $clog2(WIN_LEN + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

  logic signed [ACC_W-1:0] acc_q, acc_d, vote_val, sum;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    up_q, up_d, dn_q, dn_d;
  logic                    closing;

  always_comb begin
    unique case (vote)
      VOTE_LATE:  vote_val = ACC_W'(signed'(1));
      VOTE_EARLY: vote_val = -ACC_W'(signed'(1));
      default:    vote_val = '0;
    endcase
    sum     = acc_q + vote_val;
    closing = en && !clr && (cnt_q == LAST_IDX);
    dec_up  = closing && (sum > 0);
    dec_dn  = closing && (sum < 0);
  end

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    up_d  = 1'b0;
    dn_d  = 1'b0;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (en) begin
      if (closing) begin
        acc_d = '0;
        cnt_d = '0;
        up_d  = dec_up;
        dn_d  = dec_dn;
      end else begin
        acc_d = sum;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
    end
  end

  assign step_up = up_q;
  assign step_dn = dn_q;

endmodule

// File: rtl/cdr_phase_state.sv
module cdr_phase_state #(
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned RST_PHASE = 128,
  parameter bit          SATURATE  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PHASE_W-1:0] load_val,
  input  logic               inc,
  input  logic               dec,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] PH_MAX  = {PHASE_W{1'b1}};
  localparam logic [PHASE_W-1:0] PH_MIN  = '0;
  localparam logic [PHASE_W-1:0] PH_INIT = PHASE_W'(RST_PHASE);

  logic [PHASE_W-1:0] ph_q, ph_d, ph_step;
  logic               at_max, at_min;

  always_comb begin
    at_max = (ph_q == PH_MAX);
    at_min = (ph_q == PH_MIN);
  end

  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        ph_step = ph_q;
        if (inc && !at_max) begin
          ph_step = ph_q + 1'b1;
        end else if (dec && !at_min) begin
          ph_step = ph_q - 1'b1;
        end
      end
    end else begin : g_wrap
      always_comb begin
        ph_step = ph_q;
        if (inc) begin
          ph_step = ph_q + 1'b1;
        end else if (dec) begin
          ph_step = ph_q - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    if (load) begin
      ph_d = load_val;
    end else begin
      ph_d = ph_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_INIT;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_pkg::*;
#(
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned WIN_LEN   = 4,
  parameter int unsigned RST_PHASE = RESET_PHASE_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_load,
  input  logic [PHASE_W-1:0] init_phase,
  input  logic               smp_valid,
  input  logic               d_cur,
  input  logic               d_prev,
  input  logic               e_smp,
  output logic               step_up,
  output logic               step_dn,
  output logic [PHASE_W-1:0] phase_code
);

  vote_t vote;
  logic  dec_up, dec_dn;

  cdr_edge_classifier u_cls (
    .d_cur  (d_cur),
    .d_prev (d_prev),
    .e_smp  (e_smp),
    .vote   (vote)
  );

  cdr_vote_filter #(
    .WIN_LEN (WIN_LEN)
  ) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (init_load),
    .en      (smp_valid),
    .vote    (vote),
    .dec_up  (dec_up),
    .dec_dn  (dec_dn),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  cdr_phase_state #(
    .PHASE_W   (PHASE_W),
    .RST_PHASE (RST_PHASE),
    .SATURATE  (1'b1)
  ) u_ph (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (init_load),
    .load_val (init_phase),
    .inc      (dec_up),
    .dec      (dec_dn),
    .phase    (phase_code)
  );

endmodule

// File: rtl/cdr_phase_ctrl_chk.sv
module cdr_phase_ctrl_chk #(
  parameter int unsigned PHASE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_load,
  input logic [PHASE_W-1:0] init_phase,
  input logic               smp_valid,
  input logic               step_up,
  input logic               step_dn,
  input logic [PHASE_W-1:0] phase_code
);

  localparam logic [PHASE_W-1:0] PMAX = {PHASE_W{1'b1}};

  assert_excl_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  assert_up_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && $past(phase_code) != PMAX)
      |-> phase_code == PHASE_W'($past(phase_code) + 1'b1));

  assert_dn_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && $past(phase_code) != '0)
      |-> phase_code == PHASE_W'($past(phase_code) - 1'b1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !$past(init_load)) |-> $stable(phase_code));

  assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_code) == PMAX && !$past(init_load)) |-> phase_code == PMAX || step_dn);

  assert_no_wrap_bot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_code) == '0 && !$past(init_load)) |-> phase_code == '0 || step_up);

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_load) |-> (phase_code == $past(init_phase)) && !step_up && !step_dn);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> !step_up && !step_dn);

endmodule

bind cdr_phase_ctrl cdr_phase_ctrl_chk #(
  .PHASE_W (PHASE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_load  (init_load),
  .init_phase (init_phase),
  .smp_valid  (smp_valid),
  .step_up    (step_up),
  .step_dn    (step_dn),
  .phase_code (phase_code)
);

// File: tb/cdr_phase_ctrl_bench.sv
`timescale 1ns/1ps
module cdr_phase_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_load;
  logic [7:0] init_phase;
  logic       smp_valid, d_cur, d_prev, e_smp;
  logic       step_up, step_dn;
  logic [7:0] phase_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int m_ph, m_acc, m_cnt;
  bit m_up, m_dn;

  always #2 clk = ~clk;

  cdr_phase_ctrl u_cdr_phase_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_load  (init_load),
    .init_phase (init_phase),
    .smp_valid  (smp_valid),
    .d_cur      (d_cur),
    .d_prev     (d_prev),
    .e_smp      (e_smp),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .phase_code (phase_code)
  );

  task automatic check_outs(input string req);
    total++;
    if (phase_code !== 8'(m_ph) || step_up !== m_up || step_dn !== m_dn) begin
      bad++;
      $display("FAIL %s: got phase=%0d up=%0b dn=%0b expected phase=%0d up=%0b dn=%0b",
               req, phase_code, step_up, step_dn, m_ph, m_up, m_dn);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, update the model, check at the next falling edge.
  task automatic cyc(input bit v, input bit dc, input bit dp, input bit e,
                     input bit ld, input int ldv, input string req);
    int vote, sum;
    smp_valid  = v;  d_cur = dc; d_prev = dp; e_smp = e;
    init_load  = ld; init_phase = 8'(ldv);
    @(posedge clk);
    m_up = 1'b0; m_dn = 1'b0;
    if (ld) begin
      m_ph = ldv; m_acc = 0; m_cnt = 0;
    end else if (v) begin
      vote = (dc == dp) ? 0 : ((e == dc) ? -1 : 1);
      sum  = m_acc + vote;
      if (m_cnt == 3) begin
        m_up = (sum > 0); m_dn = (sum < 0);
        if (m_up && m_ph < 255) m_ph++;
        if (m_dn && m_ph > 0)   m_ph--;
        m_acc = 0; m_cnt = 0;
      end else begin
        m_acc = sum; m_cnt++;
      end
    end
    @(negedge clk);
    check_outs(req);
  endtask

  task automatic window(input bit dc, input bit dp, input bit e, input string req);
    for (int k = 0; k < 4; k++) cyc(1'b1, dc, dp, e, 1'b0, 0, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; init_load = 1'b0; init_phase = '0;
    smp_valid = 1'b0; d_cur = 1'b0; d_prev = 1'b0; e_smp = 1'b0;
    m_ph = 128; m_acc = 0; m_cnt = 0; m_up = 1'b0; m_dn = 1'b0;
    repeat (3) @(negedge clk);
    check_outs("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R8 after release");

    // R1 R2: every sample combination, one full window each
    for (int c = 0; c < 8; c++) window(c[0], c[1], c[2], "R1 R2 pattern sweep");

    // R4: balanced window gives no step
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R4 balanced");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R4 balanced");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R4 balanced");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R4 balanced");

    // R9: idle gaps inside a window do not advance it
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R9 gap");
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R9 idle");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 window close");

    // R6 with R7: step at the upper limit
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 254, "R7 load 254");
    for (int k = 0; k < 3; k++) window(1'b1, 1'b0, 1'b0, "R6 top saturate");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, "R7 load 1");
    for (int k = 0; k < 3; k++) window(1'b1, 1'b0, 1'b1, "R6 bottom saturate");

    // R7: load in the middle of a window restarts it
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 partial");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 partial");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 77, "R7 mid-window load");
    window(1'b0, 1'b1, 1'b1, "R3 fresh window");

    // Long pseudo-random sequence covering R1 to R9 together
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      bit ld;
      int lv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ld = (lf[15:10] == 6'd0);
      lv = lf[5] ? (lf[6] ? 254 : 1) : int'(lf[13:6]);
      cyc(lf[0] | lf[1], lf[2], lf[3], lf[4], ld, lv, "R3 R5 R9 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule